// File: doc/BRIEF.md
# Spin Lock Acquire/Release Sequencer

This block takes a lock word in shared memory and releases it again on behalf of one requester. When it receives an acquire request, it polls the lock word with plain reads for as long as the word reads non-zero. Once a read returns zero, it issues one atomic swap that stores 1 and returns the previous contents. The lock is granted only if that swap returned zero. If the swap returned a non-zero value, another agent took the word between the read and the swap, so the sequencer counts a failed attempt and goes back to polling.

A release request stores 0 to the lock word. The grant output stays high until the memory acknowledges that store. A release issued while the lock is not held does nothing except raise a one-cycle error pulse. The memory side is a single request/response port with read, write and swap operations, and it never has more than one request outstanding.

Top module: `spin_lock_seq`

## Requirements
- R1: After reset, `mem_req_o`, `granted_o` and `err_o` are 0 and `retry_cnt_o` is 0.
- R2: The memory opcode encoding is read = 0, write = 1, swap = 2. Every request carries `lock_addr_i` as its address. A request stays asserted with stable opcode and data until `mem_ready_i` accepts it. No new request is issued until `mem_rvalid_i` has returned the response to the previous one.
- R3: An acquire pulse in the idle state starts a read of the lock word. Each read that returns a non-zero word is followed by another read.
- R4: A read that returns 0 is followed by a swap request whose write data is 1.
- R5: `granted_o` rises on the cycle after a swap response of 0. A swap response that is non-zero leads to a new read and adds one to the retry count.
- R6: A release pulse while the lock is held issues a write of 0. `granted_o` stays 1 up to and including the cycle in which that write is acknowledged, and is 0 on the cycle after.
- R7: A release pulse while `granted_o` is 0 starts no memory request and has no effect on the sequence. `err_o` is 1 for exactly the following cycle.
- R8: An acquire pulse while an acquisition is in progress or the lock is held starts no memory request.
- R9: `retry_cnt_o` never decreases and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_i | input | 1 | Acquire request pulse |
| rel_i | input | 1 | Release request pulse |
| lock_addr_i | input | ADDR_W | Address of the lock word |
| granted_o | output | 1 | Lock held by this requester |
| err_o | output | 1 | Release seen while the lock was not held |
| retry_cnt_o | output | CNT_W | Saturating count of failed swaps |
| mem_req_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_op_o | output | 2 | Opcode: 0 read, 1 write, 2 swap |
| mem_addr_o | output | ADDR_W | Request address |
| mem_wdata_o | output | DATA_W | Write or swap data |
| mem_rvalid_i | input | 1 | Response valid |
| mem_rdata_i | input | DATA_W | Read or swap old value |

## Verification
The bench targets three situations:

- **Lost race.** The memory model reports the lock word as free on the read and then returns a taken value from the swap. A design that granted on the read alone, or that stayed in a swap loop instead of polling again, would produce the wrong transaction sequence.
- **Held word.** The word reads as taken for several polls. A design that swapped without first reading zero would be caught by the scoreboard.
- **Grant timing and stray requests.** The grant is sampled on the cycle the release write is acknowledged and on the cycle after, which catches a design that drops the grant early. Stray release and acquire pulses are checked for spurious memory traffic and for the error pulse.

The retry counter is driven past its maximum to expose wrap-around.

// File: rtl/spin_lock_pkg.sv
package spin_lock_pkg;
  typedef enum logic [1:0] {
    MEM_RD   = 2'd0,
    MEM_WR   = 2'd1,
    MEM_SWAP = 2'd2
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_SW_REQ,
    ST_SW_WAIT,
    ST_HELD,
    ST_WR_REQ,
    ST_WR_WAIT
  } seq_state_e;
endpackage

// File: rtl/spin_sat_cnt.sv
module spin_sat_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (inc_i && cnt_o != CntMax) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/spin_lock_fsm.sv
module spin_lock_fsm
  import spin_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acq_i,
  input  logic              rel_i,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic [1:0]        mem_op_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              granted_o,
  output logic              err_o,
  output logic              swap_fail_o
);
  localparam logic [DATA_W-1:0] Unlocked = '0;
  localparam logic [DATA_W-1:0] Locked   = DATA_W'(1);

  seq_state_e state_q, state_d;
  logic       err_q;
  logic       rd_free;

  assign rd_free = (mem_rdata_i == Unlocked);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (acq_i) state_d = ST_RD_REQ;
      ST_RD_REQ:  if (mem_ready_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rvalid_i) state_d = rd_free ? ST_SW_REQ : ST_RD_REQ;
      ST_SW_REQ:  if (mem_ready_i) state_d = ST_SW_WAIT;
      ST_SW_WAIT: if (mem_rvalid_i) state_d = rd_free ? ST_HELD : ST_RD_REQ;
      ST_HELD:    if (rel_i) state_d = ST_WR_REQ;
      ST_WR_REQ:  if (mem_ready_i) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_rvalid_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= rel_i && !granted_o;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_op_o    = MEM_RD;
    mem_wdata_o = Unlocked;
    unique case (state_q)
      ST_RD_REQ: mem_req_o = 1'b1;
      ST_SW_REQ: begin
        mem_req_o   = 1'b1;
        mem_op_o    = MEM_SWAP;
        mem_wdata_o = Locked;
      end
      ST_WR_REQ: begin
        mem_req_o = 1'b1;
        mem_op_o  = MEM_WR;
      end
      default: ;
    endcase
  end

  // grant covers the release write until its acknowledge
  assign granted_o   = (state_q == ST_HELD) || (state_q == ST_WR_REQ) ||
                       (state_q == ST_WR_WAIT);
  assign err_o       = err_q;
  assign swap_fail_o = (state_q == ST_SW_WAIT) && mem_rvalid_i && !rd_free;
endmodule

// File: rtl/spin_lock_seq.sv
module spin_lock_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acq_i,
  input  logic              rel_i,
  input  logic [ADDR_W-1:0] lock_addr_i,
  output logic              granted_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  retry_cnt_o,
  output logic              mem_req_o,
  input  logic              mem_ready_i,
  output logic [1:0]        mem_op_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic swap_fail;

  spin_lock_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acq_i       (acq_i),
    .rel_i       (rel_i),
    .mem_ready_i (mem_ready_i),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_op_o    (mem_op_o),
    .mem_wdata_o (mem_wdata_o),
    .granted_o   (granted_o),
    .err_o       (err_o),
    .swap_fail_o (swap_fail)
  );

  spin_sat_cnt #(.CNT_W(CNT_W)) i_retry (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (swap_fail),
    .cnt_o (retry_cnt_o)
  );

  assign mem_addr_o = lock_addr_i;
endmodule

// File: rtl/spin_lock_chk.sv
module spin_lock_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rel_i,
  input logic              granted_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  retry_cnt_o,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic [1:0]        mem_op_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_rvalid_i,
  input logic [DATA_W-1:0] mem_rdata_i
);
  logic       outst_q;
  logic [1:0] last_op_q;
  logic       accept;

  assign accept = mem_req_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q   <= 1'b0;
      last_op_q <= 2'd0;
    end else begin
      if (accept) begin
        outst_q   <= 1'b1;
        last_op_q <= mem_op_o;
      end else if (mem_rvalid_i) begin
        outst_q <= 1'b0;
      end
    end
  end

  a_r2_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !mem_req_o);

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_op_o) && $stable(mem_wdata_o));

  a_r4_swap_writes_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_op_o == 2'd2 |-> mem_wdata_o == DATA_W'(1));

  a_r5_grant_after_zero_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(granted_o) |-> $past(mem_rvalid_i) && $past(mem_rdata_i) == '0 && last_op_q == 2'd2);

  a_r6_release_writes_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_op_o == 2'd1 |-> mem_wdata_o == '0 && granted_o);

  a_r7_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rel_i) && !$past(granted_o));

  a_r9_retry_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_cnt_o != $past(retry_cnt_o) |-> retry_cnt_o == $past(retry_cnt_o) + 1'b1);
endmodule

bind spin_lock_seq spin_lock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rel_i       (rel_i),
  .granted_o   (granted_o),
  .err_o       (err_o),
  .retry_cnt_o (retry_cnt_o),
  .mem_req_o   (mem_req_o),
  .mem_ready_i (mem_ready_i),
  .mem_op_o    (mem_op_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rvalid_i(mem_rvalid_i),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/test_spin_lock_seq.sv
module test_spin_lock_seq;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 2;
  localparam logic [AW-1:0] LockAddr = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq = 1'b0, rel = 1'b0;
  logic granted, err, req, ready = 1'b0, rvalid = 1'b0;
  logic [CW-1:0] retry;
  logic [1:0] op;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata = '0;

  always #5 clk = ~clk;

  spin_lock_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_spin_lock_seq (
    .clk_i(clk), .rst_ni(rst_n), .acq_i(acq), .rel_i(rel), .lock_addr_i(LockAddr),
    .granted_o(granted), .err_o(err), .retry_cnt_o(retry),
    .mem_req_o(req), .mem_ready_i(ready), .mem_op_o(op), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata));

  typedef struct { logic [1:0] op; logic [DW-1:0] wd; } exp_t;
  exp_t exp_q[$];

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] word = '0;
  int hold_reads = 0, steals = 0;
  logic [1:0] last_op = 2'd0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] o, input logic [DW-1:0] d);
    exp_t e;
    e.op = o; e.wd = d;
    exp_q.push_back(e);
  endtask

  // memory model and scoreboard monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      ready  <= 1'b0;
    end else begin
      ready  <= ~ready;
      rvalid <= 1'b0;
      if (req && ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8/R7 unexpected request", {62'd0, op}, 64'hff);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(op == e.op, "R2/R3/R4 opcode", op, e.op);
          chk(wdata == e.wd, "R4/R6 wdata", wdata, e.wd);
          chk(addr == LockAddr, "R2 address", addr, LockAddr);
        end
        last_op <= op;
        rvalid  <= 1'b1;
        case (op)
          2'd0: if (hold_reads > 0) begin rdata <= 1; hold_reads--; end
                else rdata <= word;
          2'd2: if (steals > 0) begin rdata <= 1; steals--; hold_reads = 1; end
                else begin rdata <= word; word = 1; end
          default: begin word = wdata; rdata <= '0; end
        endcase
      end
    end
  end

  task automatic pulse_acq();
    @(posedge clk); #1 acq = 1'b1;
    @(posedge clk); #1 acq = 1'b0;
  endtask

  task automatic wait_grant();
    while (!granted) @(negedge clk);
    chk(exp_q.size() == 0, "R5 sequence complete at grant", exp_q.size(), 0);
  endtask

  task automatic release_lock();
    push(2'd1, '0);
    @(posedge clk); #1 rel = 1'b1;
    @(posedge clk); #1 rel = 1'b0;
    @(negedge clk);
    chk(err == 1'b0, "R6 no error on valid release", err, 0);
    while (!(rvalid && last_op == 2'd1)) @(negedge clk);
    chk(granted == 1'b1, "R6 grant held at write ack", granted, 1);
    @(negedge clk);
    chk(granted == 1'b0, "R6 grant dropped after ack", granted, 0);
    chk(word == '0, "R6 lock word cleared", word, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req == 0 && granted == 0 && err == 0 && retry == 0, "R1 reset state",
        {req, granted, err, retry}, 0);
    #1 rst_n = 1'b1;

    // R7: release while idle
    @(posedge clk); #1 rel = 1'b1;
    @(posedge clk); #1 rel = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R7 err pulse on stray release", err, 1);
    @(negedge clk);
    chk(err == 1'b0, "R7 err lasts one cycle", err, 0);
    repeat (4) @(negedge clk);
    chk(granted == 0 && req == 0, "R7 stray release ignored", {granted, req}, 0);

    // R3 R4 R5: free lock
    push(2'd0, '0); push(2'd2, 1);
    pulse_acq();
    wait_grant();
    chk(retry == 0, "R5 no retry on free lock", retry, 0);

    // R8: acquire while held
    pulse_acq();
    repeat (6) @(negedge clk);
    chk(granted == 1 && req == 0, "R8 acquire while held ignored", {granted, req}, 2'b10);
    release_lock();

    // R3: word held for three polls
    hold_reads = 3;
    for (int i = 0; i < 4; i++) push(2'd0, '0);
    push(2'd2, 1);
    pulse_acq();
    wait_grant();
    chk(retry == 0, "R3 polling does not count retries", retry, 0);
    release_lock();

    // R5: lost race once
    steals = 1;
    push(2'd0, '0);
    push(2'd2, 1); push(2'd0, '0); push(2'd0, '0);
    push(2'd2, 1);
    pulse_acq();
    wait_grant();
    chk(retry == 1, "R5 retry counted", retry, 1);
    release_lock();

    // R9: saturate, R7/R8 during spin
    steals = 4;
    push(2'd0, '0);
    for (int i = 0; i < 4; i++) begin
      push(2'd2, 1); push(2'd0, '0); push(2'd0, '0);
    end
    push(2'd2, 1);
    pulse_acq();
    repeat (3) @(posedge clk);
    #1 rel = 1'b1; acq = 1'b1;
    @(posedge clk); #1 rel = 1'b0; acq = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R7 err on release during spin", err, 1);
    chk(granted == 1'b0, "R7 release during spin no grant change", granted, 0);
    wait_grant();
    chk(retry == 2'd3, "R9 retry saturates", retry, 3);
    release_lock();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule